// File: doc/BRIEF.md
# Core Status and Error Register

This block holds the status word of a memory-mapped crypto or entropy core and decodes the CPU bus accesses to it. The word carries the core's ready and valid flags, one sticky flag that records any misuse of the core's register interface, and a field of per-source health-failure flags. The core's datapath reports API misuse and health-monitor failures as one-cycle pulses. The core's datapath and the system-level interrupt aggregator are outside this block.

The block treats the two error classes differently. API misuse happens in step with the software that caused it, so it only sets the sticky flag, which software finds on its next status read. A health failure can happen at any time, so it sets its own flag and also raises a registered error line that a system-level interrupt aggregator consumes. Both classes stay set until software writes the clear command to the control word. A flag whose source is still failing survives the clear.

Top module: `core_status_regs`

## Requirements
- R1: After reset, a status read returns 0 and `err_irq_o` is 0.
- R2: Status bit 0 shows `ready_i` and status bit 1 shows `valid_i`. Each is registered once before it appears in the word.
- R3: A `viol_pulse_i` pulse sets status bit 2. The bit stays set through any number of status reads.
- R4: A write to address 1 with data bit 0 high clears bit 2 and all health bits. A write to address 1 with data bit 0 low changes nothing.
- R5: `health_fail_i[i]` sets status bit 24+i. Entropy sources 0 to 2 map to bits 24 to 26, and the output-generator monitor maps to bit 27.
- R6: A health failure never sets status bit 2.
- R7: `err_irq_o` is high one cycle after any health bit is set. It returns low one cycle after all health bits are cleared.
- R8: A clear in the same cycle as an active failure or violation input leaves the matching bit set.
- R9: Reads of address 1 or of any unmapped address return 0. Status bits 3 to 23 always read 0.
- R10: Writes to the status address (0) are ignored and do not count as violations.
- R11: Read data appears on `rdata_o` in the cycle after the read request. It is 0 in every cycle that follows a cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Bus select |
| we_i | input | 1 | Write enable (0 = read) |
| addr_i | input | 4 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| ready_i | input | 1 | Core ready flag |
| valid_i | input | 1 | Core result-valid flag |
| viol_pulse_i | input | 1 | API misuse pulse |
| health_fail_i | input | 4 | Per-monitor health failure |
| err_irq_o | output | 1 | Registered health error line |

## Verification
Every flag input is captured at the first clock edge after it is driven. A read issued in the next cycle returns the updated word one edge later. `err_irq_o` follows a health bit by exactly one more edge. The bench drives inputs and samples outputs on falling edges. Its driver tasks push the expected read word into a queue when they issue a read. A monitor pops that entry at the falling edge after the read was captured and compares it there. The error line is checked at the falling edge after the edge that updated the health bits, and the idle-zero behaviour of the read data is checked at a falling edge that follows a cycle without a read.

// File: rtl/core_status_pkg.sv
package core_status_pkg;
  localparam int ADDR_W       = 4;
  localparam int DATA_W       = 32;
  localparam int BIT_READY    = 0;
  localparam int BIT_VALID    = 1;
  localparam int BIT_VIOL     = 2;
  localparam int HEALTH_LSB   = 24;
  localparam int CTRL_CLR_BIT = 0;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 4'h0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 4'h1;
endpackage

// File: rtl/status_sticky_bank.sv
module status_sticky_bank #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q, q_d;
  logic         q_en;

  // set wins over clear in the same cycle
  always_comb begin
    q_en = clr_i | (|set_i);
    q_d  = (clr_i ? '0 : q_q) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_q <= '0;
    else if (q_en) q_q <= q_d;
  end

  assign q_o = q_q;

  for (genvar i = 0; i < W; i++) begin : g_chk
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (q_o[i] && !clr_i) |=> q_o[i]); // R3
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> q_o[i]); // R8
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i[i]) |=> !q_o[i]); // R4
  end
endmodule

// File: rtl/status_bus_decode.sv
module status_bus_decode
  import core_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] status_i,
  output logic              clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              rd, wr;
  logic [DATA_W-1:0] rdata_d, rdata_q;

  always_comb begin
    rd      = cs_i & ~we_i;
    wr      = cs_i & we_i;
    clr_o   = wr && (addr_i == ADDR_CTRL) && wdata_i[CTRL_CLR_BIT];
    rdata_d = (rd && (addr_i == ADDR_STATUS)) ? status_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_i && !we_i && addr_i != ADDR_STATUS) |=> rdata_o == '0); // R9
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs_i && !we_i) |=> rdata_o == '0); // R11
endmodule

// File: rtl/status_irq_reg.sv
module status_irq_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] flags_i,
  output logic         irq_o
);
  logic irq_q, irq_d;

  always_comb irq_d = |flags_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|flags_i) |=> irq_o); // R7
  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !(|flags_i) |=> !irq_o); // R7
endmodule

// File: rtl/core_status_regs.sv
module core_status_regs
  import core_status_pkg::*;
#(
  parameter int N_HEALTH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic                ready_i,
  input  logic                valid_i,
  input  logic                viol_pulse_i,
  input  logic [N_HEALTH-1:0] health_fail_i,
  output logic                err_irq_o
);
  localparam int HEALTH_MSB = HEALTH_LSB + N_HEALTH - 1;

  logic                rdy_q, vld_q;
  logic                clr;
  logic                viol_q;
  logic [N_HEALTH-1:0] health_q;
  logic [DATA_W-1:0]   status_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      rdy_q <= ready_i;
      vld_q <= valid_i;
    end
  end

  status_sticky_bank #(.W(1)) u_viol (
    .clk(clk), .rst_n(rst_n), .set_i(viol_pulse_i), .clr_i(clr), .q_o(viol_q)
  );

  status_sticky_bank #(.W(N_HEALTH)) u_health (
    .clk(clk), .rst_n(rst_n), .set_i(health_fail_i), .clr_i(clr), .q_o(health_q)
  );

  status_irq_reg #(.W(N_HEALTH)) u_irq (
    .clk(clk), .rst_n(rst_n), .flags_i(health_q), .irq_o(err_irq_o)
  );

  always_comb begin
    status_word                        = '0;
    status_word[BIT_READY]             = rdy_q;
    status_word[BIT_VALID]             = vld_q;
    status_word[BIT_VIOL]              = viol_q;
    status_word[HEALTH_MSB:HEALTH_LSB] = health_q;
  end

  status_bus_decode u_dec (
    .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .status_i(status_word), .clr_o(clr), .rdata_o(rdata_o)
  );

  AST_HEALTH_NOT_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
    ((|health_fail_i) && !viol_pulse_i && !viol_q) |=> !viol_q); // R6
  AST_STATUS_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_i && we_i && addr_i == ADDR_STATUS && !viol_pulse_i && !viol_q) |=> !viol_q); // R10
  AST_RDY_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    ready_i |=> rdy_q); // R2
endmodule

// File: tb/tb_core_status_regs.sv
module tb_core_status_regs;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs, we;
  logic [3:0]  addr;
  logic [31:0] wdata, rdata;
  logic        ready, valid, viol;
  logic [3:0]  health;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic rd_seen = 1'b0;
  logic done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk; // 125 MHz

  core_status_regs dut (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ready_i(ready), .valid_i(valid),
    .viol_pulse_i(viol), .health_fail_i(health), .err_irq_o(irq)
  );

  always @(posedge clk) rd_seen <= cs && !we;

  // monitor: compares read data one edge after each captured read
  always @(negedge clk) begin
    if (rd_seen) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL unexpected read data (scoreboard empty): actual %h expected none", rdata);
      end else begin
        item_t it;
        it = sb.pop_front();
        if (rdata !== it.exp) begin
          errors++;
          $display("FAIL %s: rdata actual %h expected %h", it.req, rdata, it.exp);
        end
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    cs = 1'b1; we = 1'b0; addr = a;
    sb.push_back('{exp, req});
    @(negedge clk);
    cs = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic hpulse(input logic [3:0] v);
    @(negedge clk);
    health = v;
    @(negedge clk);
    health = '0;
  endtask

  initial begin
    rst_n = 1'b0; cs = 0; we = 0; addr = 0; wdata = 0;
    ready = 0; valid = 0; viol = 0; health = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    rd(4'h0, 32'h0, "R1 status after reset");

    ready = 1'b1;
    rd(4'h0, 32'h1, "R2 ready bit");
    valid = 1'b1;
    rd(4'h0, 32'h3, "R2 valid bit");

    @(negedge clk); viol = 1'b1;
    @(negedge clk); viol = 1'b0;
    rd(4'h0, 32'h7, "R3 violation set");
    rd(4'h0, 32'h7, "R3 read does not clear");

    wr(4'h1, 32'h0);
    rd(4'h0, 32'h7, "R4 write without clear bit");
    wr(4'h1, 32'h1);
    rd(4'h0, 32'h3, "R4 clear");

    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, 32'h3, "R10 status write ignored");

    rd(4'h1, 32'h0, "R9 control reads zero");
    rd(4'h5, 32'h0, "R9 unmapped reads zero");
    @(negedge clk);
    check("R11 idle rdata zero", rdata, 32'h0);

    hpulse(4'b0001);
    @(negedge clk);
    check("R7 irq raised", {31'b0, irq}, 32'h1);
    rd(4'h0, 32'h0100_0003, "R5 R6 source 0 bit 24, no violation");
    hpulse(4'b1000);
    rd(4'h0, 32'h0900_0003, "R5 generator monitor bit 27");
    hpulse(4'b0100);
    rd(4'h0, 32'h0D00_0003, "R5 source 2 bit 26");

    wr(4'h1, 32'h1);
    @(negedge clk);
    check("R7 irq dropped after clear", {31'b0, irq}, 32'h0);
    rd(4'h0, 32'h3, "R4 health bits cleared");

    @(negedge clk); health = 4'b0010;
    wr(4'h1, 32'h1);
    health = '0;
    rd(4'h0, 32'h0200_0003, "R8 active failure survives clear");
    wr(4'h1, 32'h1);
    rd(4'h0, 32'h3, "R8 later clear works");

    @(negedge clk);
    cs = 1'b1; we = 1'b1; addr = 4'h1; wdata = 32'h1; viol = 1'b1;
    @(negedge clk);
    cs = 1'b0; we = 1'b0; viol = 1'b0;
    rd(4'h0, 32'h7, "R8 violation survives coincident clear");
    wr(4'h1, 32'h1);
    rd(4'h0, 32'h3, "R4 violation cleared");

    repeat (2) @(negedge clk);
    check("R11 scoreboard drained", sb.size(), 32'h0);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule